// File: doc/BRIEF.md
# Byte-Stream Frame Mailbox

This block sits on a processor's register bus and passes whole network frames between software and a byte-wide network side. Software reaches the block through a 16-word window. Frames arriving on the receive stream are stored in an internal byte buffer. Software then drains the frame one byte per read of a data register, and a counter tracks how many bytes remain.

To transmit, software writes a byte count and then the bytes themselves, one per write. Once the last byte has arrived, the block plays the frame out on the transmit stream and clears the count. An interrupt register flags transmit completion, receive availability and a software test source. Its single output line is the OR of those three flags.

While a received frame is flagged as available, the receive stream is stalled. Another frame therefore cannot overwrite the buffer before software has acknowledged the current one.

Top module: `netbyte_mmio`

## Requirements
- R1: Word 0 reads the low half and word 1 the high half of the 64-bit identifier parameter `DEV_ID`. Its first character sits in the least significant byte, and the default spells "NETBYTE0". Writes to words 0 to 3 change nothing.
- R2: Word 2 reads 1 while a receive frame is partly stored or a transmit frame is being played out, and reads 0 otherwise.
- R3: When the byte marked last is taken from the receive stream, word 3 (receive count) loads the frame length and bit 1 of word 5 sets.
- R4: Each read of word 7 while the receive count is nonzero returns the next stored byte in bits 7:0, in arrival order, and lowers the count by one. With the count at zero, a read returns 0 and changes nothing.
- R5: While bit 1 of word 5 is set, `rxReady` is low and offered bytes are not stored.
- R6: A write to word 4 of a value from 1 to `MAX_BYTES` sets the transmit count; any other value is ignored. Each write to word 8 while the count is nonzero and no frame is playing stores bits 7:0. Writes to word 8 at other times are ignored. When the counted byte arrives, word 4 reads 0 and the frame starts on the stream.
- R7: The transmit stream presents the bytes in write order and raises `txLast` with the final byte only. It holds data and last steady while `txReady` is low.
- R8: Bit 0 of word 5 sets when the final transmit byte is accepted by the stream.
- R9: Writing 1 to bit 0 or bit 1 of word 5 clears that bit. Writing 0 to either leaves it unchanged.
- R10: Writing 1 to bit 31 of word 5 sets the test bit. A read of word 5 returns the bit and then clears it. Writing 0 to bit 31 also clears it.
- R11: `irq` is high exactly when bit 0, bit 1 or bit 31 of word 5 is set.
- R12: Word 6 reads the constant `INFO_WORD` (default 1) and ignores writes. Words 9 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Word address within the window |
| busWrEn | input | 1 | Write strobe, one cycle per access |
| busRdEn | input | 1 | Read strobe, one cycle per access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Interrupt request |
| rxValid | input | 1 | Receive byte offered |
| rxReady | output | 1 | Receive byte can be taken |
| rxData | input | 8 | Receive byte |
| rxLast | input | 1 | Receive byte ends the frame |
| txValid | output | 1 | Transmit byte offered |
| txReady | input | 1 | Transmit byte taken by the network side |
| txData | output | 8 | Transmit byte |
| txLast | output | 1 | Transmit byte ends the frame |

## Verification
Receive is tried with a five-byte frame split around a busy-flag read, with a one-byte frame, and with a byte offered while the done flag is pending. Together these separate correct length loading, ordering and back-pressure from a buffer that overwrites or miscounts. Transmit is tried with out-of-range counts, with stray data writes while idle, and with a stall pattern on `txReady`. These expose a count that accepts bad values, data that shifts during a stall, or a last marker on the wrong byte. Interrupt writes of mixed ones and zeros, and repeated reads of the test bit, tell write-one-to-clear apart from plain write and read-clear apart from sticky behaviour.

// File: rtl/netbyte_pkg.sv
package netbyte_pkg;

  localparam int WORD_W = 32;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] REG_ID_LO   = 4'd0;
  localparam logic [ADDR_W-1:0] REG_ID_HI   = 4'd1;
  localparam logic [ADDR_W-1:0] REG_BUSY    = 4'd2;
  localparam logic [ADDR_W-1:0] REG_RX_CNT  = 4'd3;
  localparam logic [ADDR_W-1:0] REG_TX_CNT  = 4'd4;
  localparam logic [ADDR_W-1:0] REG_INT     = 4'd5;
  localparam logic [ADDR_W-1:0] REG_INFO    = 4'd6;
  localparam logic [ADDR_W-1:0] REG_RX_DATA = 4'd7;
  localparam logic [ADDR_W-1:0] REG_TX_DATA = 4'd8;

  // Interrupt bit positions (software-visible)
  localparam int INT_TX_BIT   = 0;
  localparam int INT_RX_BIT   = 1;
  localparam int INT_TEST_BIT = 31;

  // Strobes from control to datapath
  typedef struct packed {
    logic rxPop;
    logic txCntWr;
    logic txDataWr;
  } nbStrobes_t;

endpackage

// File: rtl/netbyte_ctrl.sv
module netbyte_ctrl
  import netbyte_pkg::*;
#(
  parameter int          CNT_W     = 17,
  parameter logic [63:0] DEV_ID    = 64'h0,
  parameter logic [31:0] INFO_WORD = 32'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [2:0]        intWrBits,   // {bit31, bit1, bit0} of write data
  output logic [WORD_W-1:0] busRdata,
  output logic              irq,
  output nbStrobes_t        strb,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [7:0]        rxByte,
  input  logic              rxFrameDone,
  input  logic              txFrameDone,
  input  logic              busyFlag,
  output logic              rxDoneFlag,
  output logic              txDoneFlag,
  output logic              testFlag
);

  localparam int PAD_W = WORD_W - CNT_W;

  logic              intWr;
  logic              intRd;
  logic [WORD_W-1:0] readWord;

  assign intWr = busWrEn && (busAddr == REG_INT);
  assign intRd = busRdEn && (busAddr == REG_INT);

  always_comb begin
    strb          = '0;
    strb.rxPop    = busRdEn && (busAddr == REG_RX_DATA) && (rxCount != '0);
    strb.txCntWr  = busWrEn && (busAddr == REG_TX_CNT);
    strb.txDataWr = busWrEn && (busAddr == REG_TX_DATA);
  end

  // Interrupt flags: hardware sets win over software clears
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txDoneFlag <= 1'b0;
      rxDoneFlag <= 1'b0;
      testFlag   <= 1'b0;
    end else begin
      txDoneFlag <= txFrameDone | (txDoneFlag & ~(intWr & intWrBits[0]));
      rxDoneFlag <= rxFrameDone | (rxDoneFlag & ~(intWr & intWrBits[1]));
      if (intWr)      testFlag <= intWrBits[2];
      else if (intRd) testFlag <= 1'b0;
    end
  end

  assign irq = txDoneFlag | rxDoneFlag | testFlag;

  always_comb begin
    readWord = '0;
    case (busAddr)
      REG_ID_LO:   readWord = DEV_ID[31:0];
      REG_ID_HI:   readWord = DEV_ID[63:32];
      REG_BUSY:    readWord = {{(WORD_W-1){1'b0}}, busyFlag};
      REG_RX_CNT:  readWord = {{PAD_W{1'b0}}, rxCount};
      REG_TX_CNT:  readWord = {{PAD_W{1'b0}}, txCount};
      REG_INT: begin
        readWord[INT_TX_BIT]   = txDoneFlag;
        readWord[INT_RX_BIT]   = rxDoneFlag;
        readWord[INT_TEST_BIT] = testFlag;
      end
      REG_INFO:    readWord = INFO_WORD;
      REG_RX_DATA: readWord = (rxCount != '0) ? {24'h0, rxByte} : '0;
      default:     readWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        busRdata <= '0;
    else if (busRdEn) busRdata <= readWord;
  end

endmodule

// File: rtl/netbyte_datapath.sv
module netbyte_datapath
  import netbyte_pkg::*;
#(
  parameter int MAX_BYTES = 2048,
  parameter int CNT_W     = 17,
  parameter int PTR_W     = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  nbStrobes_t        strb,
  input  logic [WORD_W-1:0] busWdata,
  input  logic              rxBlock,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxLast,
  output logic              rxReady,
  output logic              txValid,
  input  logic              txReady,
  output logic [7:0]        txData,
  output logic              txLast,
  output logic [CNT_W-1:0]  rxCount,
  output logic [CNT_W-1:0]  txCount,
  output logic [7:0]        rxByte,
  output logic              rxFrameDone,
  output logic              txFrameDone,
  output logic              busyFlag
);

  localparam logic [CNT_W-1:0]  MAX_CNT  = CNT_W'(MAX_BYTES);
  localparam logic [WORD_W-1:0] MAX_WORD = WORD_W'(MAX_BYTES);

  logic [7:0] rxMem [MAX_BYTES];
  logic [7:0] txMem [MAX_BYTES];

  // ---------------- receive side ----------------
  logic [CNT_W-1:0] rxWrPtr;
  logic [PTR_W-1:0] rxRdPtr;
  logic             rxTake;
  logic             rxFits;
  logic [CNT_W-1:0] rxLen;

  assign rxReady     = !rxBlock;
  assign rxTake      = rxValid && rxReady;
  assign rxFits      = rxWrPtr < MAX_CNT;
  assign rxLen       = rxFits ? rxWrPtr + CNT_W'(1) : rxWrPtr;
  assign rxFrameDone = rxTake && rxLast;
  assign rxByte      = rxMem[rxRdPtr];

  always_ff @(posedge clk) begin
    if (rxTake && rxFits) rxMem[rxWrPtr[PTR_W-1:0]] <= rxData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxWrPtr <= '0;
      rxRdPtr <= '0;
      rxCount <= '0;
    end else begin
      if (rxTake) begin
        if (rxLast)      rxWrPtr <= '0;
        else if (rxFits) rxWrPtr <= rxWrPtr + CNT_W'(1);
      end
      if (rxFrameDone) begin
        rxCount <= rxLen;
        rxRdPtr <= '0;
      end else if (strb.rxPop) begin
        rxCount <= rxCount - CNT_W'(1);
        rxRdPtr <= rxRdPtr + PTR_W'(1);
      end
    end
  end

  // ---------------- transmit side ----------------
  logic [CNT_W-1:0] txFill;
  logic [CNT_W-1:0] txLen;
  logic [CNT_W-1:0] txRdPtr;
  logic             txSending;
  logic             cntValid;
  logic             txStore;
  logic             txFillDone;

  assign cntValid    = (busWdata != '0) && (busWdata <= MAX_WORD);
  assign txStore     = strb.txDataWr && (txCount != '0) && !txSending;
  assign txFillDone  = txStore && ((txFill + CNT_W'(1)) == txCount);
  assign txValid     = txSending;
  assign txData      = txMem[txRdPtr[PTR_W-1:0]];
  assign txLast      = (txRdPtr + CNT_W'(1)) == txLen;
  assign txFrameDone = txValid && txReady && txLast;

  always_ff @(posedge clk) begin
    if (txStore) txMem[txFill[PTR_W-1:0]] <= busWdata[7:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCount   <= '0;
      txFill    <= '0;
      txLen     <= '0;
      txRdPtr   <= '0;
      txSending <= 1'b0;
    end else begin
      if (strb.txCntWr && cntValid && !txSending) begin
        txCount <= busWdata[CNT_W-1:0];
        txLen   <= busWdata[CNT_W-1:0];
        txFill  <= '0;
      end else if (txFillDone) begin
        txCount   <= '0;
        txFill    <= '0;
        txRdPtr   <= '0;
        txSending <= 1'b1;
      end else if (txStore) begin
        txFill <= txFill + CNT_W'(1);
      end
      if (txValid && txReady) begin
        txRdPtr <= txRdPtr + CNT_W'(1);
        if (txLast) txSending <= 1'b0;
      end
    end
  end

  assign busyFlag = (rxWrPtr != '0) || txSending;

endmodule

// File: rtl/netbyte_mmio.sv
module netbyte_mmio
  import netbyte_pkg::*;
#(
  parameter int          MAX_BYTES = 2048,
  parameter logic [63:0] DEV_ID    = 64'h3045_5459_4254_454E,
  parameter logic [31:0] INFO_WORD = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  output logic              irq,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic [7:0]        rxData,
  input  logic              rxLast,
  output logic              txValid,
  input  logic              txReady,
  output logic [7:0]        txData,
  output logic              txLast
);

  localparam int CNT_W = $clog2(MAX_BYTES + 1);
  localparam int PTR_W = $clog2(MAX_BYTES);

  nbStrobes_t       strb;
  logic [CNT_W-1:0] rxCount;
  logic [CNT_W-1:0] txCount;
  logic [7:0]       rxByte;
  logic             rxFrameDone;
  logic             txFrameDone;
  logic             busyFlag;
  logic             rxDoneFlag;
  logic             txDoneFlag;
  logic             testFlag;

  netbyte_ctrl #(
    .CNT_W(CNT_W), .DEV_ID(DEV_ID), .INFO_WORD(INFO_WORD)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .intWrBits({busWdata[INT_TEST_BIT], busWdata[INT_RX_BIT], busWdata[INT_TX_BIT]}),
    .busRdata(busRdata), .irq(irq), .strb(strb),
    .rxCount(rxCount), .txCount(txCount), .rxByte(rxByte),
    .rxFrameDone(rxFrameDone), .txFrameDone(txFrameDone), .busyFlag(busyFlag),
    .rxDoneFlag(rxDoneFlag), .txDoneFlag(txDoneFlag), .testFlag(testFlag)
  );

  netbyte_datapath #(
    .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W), .PTR_W(PTR_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .rxBlock(rxDoneFlag),
    .rxValid(rxValid), .rxData(rxData), .rxLast(rxLast), .rxReady(rxReady),
    .txValid(txValid), .txReady(txReady), .txData(txData), .txLast(txLast),
    .rxCount(rxCount), .txCount(txCount), .rxByte(rxByte),
    .rxFrameDone(rxFrameDone), .txFrameDone(txFrameDone), .busyFlag(busyFlag)
  );

endmodule

// File: rtl/netbyte_checker.sv
module netbyte_checker
  import netbyte_pkg::*;
#(
  parameter int MAX_BYTES = 2048,
  parameter int CNT_W     = 17
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxValid,
  input logic             rxReady,
  input logic             rxLast,
  input logic             txValid,
  input logic             txReady,
  input logic [7:0]       txData,
  input logic             txLast,
  input logic             busyFlag,
  input logic             rxDoneFlag,
  input logic             txDoneFlag,
  input logic             testFlag,
  input logic             irq,
  input nbStrobes_t       strb,
  input logic [CNT_W-1:0] rxCount
);

  p_busy_tx_r2: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> busyFlag);

  p_rx_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxReady && rxLast) |=> rxDoneFlag);

  p_pop_dec_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rxPop && !(rxValid && rxReady && rxLast)) |=> (rxCount == $past(rxCount) - CNT_W'(1)));

  p_rx_blocked_r5: assert property (@(posedge clk) disable iff (!rstN)
    rxDoneFlag |-> !rxReady);

  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData) && $stable(txLast)));

  p_tx_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && txLast) |=> txDoneFlag);

  p_irq_follows_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(testFlag) |-> irq);

  p_rx_count_limit_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= CNT_W'(MAX_BYTES));

endmodule

bind netbyte_mmio netbyte_checker #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN),
  .rxValid(rxValid), .rxReady(rxReady), .rxLast(rxLast),
  .txValid(txValid), .txReady(txReady), .txData(txData), .txLast(txLast),
  .busyFlag(busyFlag), .rxDoneFlag(rxDoneFlag), .txDoneFlag(txDoneFlag),
  .testFlag(testFlag), .irq(irq), .strb(strb), .rxCount(rxCount)
);

// File: tb/netbyte_mmio_tb.sv
module netbyte_mmio_tb_top;

  localparam int MAXB = 2048;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;
  logic        rxValid = 1'b0;
  logic        rxReady;
  logic [7:0]  rxData = '0;
  logic        rxLast = 1'b0;
  logic        txValid;
  logic        txReady = 1'b0;
  logic [7:0]  txData;
  logic        txLast;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  netbyte_mmio dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWdata(busWdata), .busRdata(busRdata), .irq(irq),
    .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData), .rxLast(rxLast),
    .txValid(txValid), .txReady(txReady), .txData(txData), .txLast(txLast)
  );

  task automatic checkEq(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdata;
  endtask

  function automatic logic [7:0] patByte(int seed, int i);
    return 8'((seed + i * 7) & 8'hFF);
  endfunction

  // Offer bytes first..first+n-1 of a frame of total bytes
  task automatic rxBytes(int seed, int first, int n, int total);
    for (int i = first; i < first + n; i++) begin
      @(negedge clk);
      rxValid = 1'b1; rxData = patByte(seed, i); rxLast = (i == total - 1);
      while (!rxReady) @(negedge clk);
    end
    @(negedge clk);
    rxValid = 1'b0; rxLast = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    checkEq("R11", "irq after reset", {31'h0, irq}, 32'h0);
    checkEq("R5", "rxReady after reset", {31'h0, rxReady}, 32'h1);
    checkEq("R7", "txValid after reset", {31'h0, txValid}, 32'h0);
    busRead(4'd2, v); checkEq("R2", "busy idle", v, 32'h0);
    busRead(4'd3, v); checkEq("R4", "rx count idle", v, 32'h0);
  endtask

  task automatic testIdent();
    logic [31:0] v;
    byte unsigned idChars[8] = '{"N", "E", "T", "B", "Y", "T", "E", "0"};
    logic [63:0] exp;
    for (int i = 0; i < 8; i++) exp[i*8 +: 8] = idChars[i];
    busRead(4'd0, v); checkEq("R1", "id low", v, exp[31:0]);
    busRead(4'd1, v); checkEq("R1", "id high", v, exp[63:32]);
    busWrite(4'd0, 32'hDEAD_BEEF);
    busWrite(4'd3, 32'h0000_0055);
    busRead(4'd0, v); checkEq("R1", "id low after write", v, exp[31:0]);
    busRead(4'd3, v); checkEq("R1", "rx count after write", v, 32'h0);
  endtask

  task automatic testRxFrame(int seed, int len);
    logic [31:0] v;
    if (len > 2) begin
      rxBytes(seed, 0, 2, len);
      busRead(4'd2, v); checkEq("R2", "busy mid rx frame", v, 32'h1);
      rxBytes(seed, 2, len - 2, len);
    end else begin
      rxBytes(seed, 0, len, len);
    end
    busRead(4'd3, v); checkEq("R3", "rx count loaded", v, 32'(len));
    busRead(4'd5, v); checkEq("R3", "rx done flag", v, 32'h2);
    checkEq("R11", "irq on rx done", {31'h0, irq}, 32'h1);
    checkEq("R5", "rxReady blocked", {31'h0, rxReady}, 32'h0);
    // offer a stray byte while blocked
    @(negedge clk);
    rxValid = 1'b1; rxData = 8'hEE; rxLast = 1'b1;
    repeat (3) @(negedge clk);
    rxValid = 1'b0; rxLast = 1'b0;
    busRead(4'd3, v); checkEq("R5", "count unchanged while blocked", v, 32'(len));
    for (int i = 0; i < len; i++) begin
      busRead(4'd7, v); checkEq("R4", "rx byte", v, {24'h0, patByte(seed, i)});
      if (i == 0) begin
        busRead(4'd3, v); checkEq("R4", "count after first pop", v, 32'(len - 1));
      end
    end
    busRead(4'd7, v); checkEq("R4", "read at zero", v, 32'h0);
    busRead(4'd3, v); checkEq("R4", "count stays zero", v, 32'h0);
    busWrite(4'd5, 32'h0000_0001);
    busRead(4'd5, v); checkEq("R9", "write 1 to bit0 leaves bit1", v, 32'h2);
    busWrite(4'd5, 32'h0000_0002);
    busRead(4'd5, v); checkEq("R9", "bit1 cleared", v, 32'h0);
    checkEq("R11", "irq low after clear", {31'h0, irq}, 32'h0);
    checkEq("R5", "rxReady back", {31'h0, rxReady}, 32'h1);
  endtask

  task automatic testTx(int seed, int len);
    logic [31:0] v;
    int got = 0;
    bit prevStall = 0;
    logic [7:0] prevData = '0;
    logic prevLast = 1'b0;
    int cyc = 0;
    busWrite(4'd8, 32'h0000_00AA);  // stray, count is zero
    checkEq("R6", "stray data no start", {31'h0, txValid}, 32'h0);
    busWrite(4'd4, 32'(len));
    busWrite(4'd4, 32'h0);
    busRead(4'd4, v); checkEq("R6", "zero count ignored", v, 32'(len));
    busWrite(4'd4, 32'(MAXB + 1));
    busRead(4'd4, v); checkEq("R6", "oversize count ignored", v, 32'(len));
    for (int i = 0; i < len; i++) begin
      busWrite(4'd8, {24'hABCDEF, patByte(seed, i)});
      if (i == len - 2) begin
        busRead(4'd4, v); checkEq("R6", "count held while filling", v, 32'(len));
        checkEq("R6", "not started early", {31'h0, txValid}, 32'h0);
      end
    end
    busRead(4'd4, v); checkEq("R6", "count cleared after fill", v, 32'h0);
    busRead(4'd2, v); checkEq("R2", "busy while sending", v, 32'h1);
    while (got < len && cyc < 200) begin
      @(negedge clk);
      cyc++;
      txReady = (cyc % 3 != 1);
      if (prevStall) begin
        checkEq("R7", "data held in stall", {24'h0, txData}, {24'h0, prevData});
        checkEq("R7", "last held in stall", {31'h0, txLast}, {31'h0, prevLast});
      end
      prevStall = txValid && !txReady;
      prevData = txData; prevLast = txLast;
      if (txValid && txReady) begin
        checkEq("R7", "tx byte", {24'h0, txData}, {24'h0, patByte(seed, got)});
        checkEq("R7", "tx last marker", {31'h0, txLast}, {31'h0, (got == len - 1)});
        got++;
      end
    end
    @(negedge clk);
    txReady = 1'b0;
    checkEq("R7", "bytes sent", 32'(got), 32'(len));
    checkEq("R7", "stream idle", {31'h0, txValid}, 32'h0);
    busRead(4'd5, v); checkEq("R8", "tx done flag", v, 32'h1);
    checkEq("R11", "irq on tx done", {31'h0, irq}, 32'h1);
    busWrite(4'd5, 32'h0000_0001);
    busRead(4'd5, v); checkEq("R9", "bit0 cleared", v, 32'h0);
    busRead(4'd2, v); checkEq("R2", "idle after send", v, 32'h0);
  endtask

  task automatic testTestBit();
    logic [31:0] v;
    busWrite(4'd5, 32'h8000_0000);
    checkEq("R11", "irq from test bit", {31'h0, irq}, 32'h1);
    busRead(4'd5, v); checkEq("R10", "test bit reads set", v, 32'h8000_0000);
    busRead(4'd5, v); checkEq("R10", "test bit read-cleared", v, 32'h0);
    checkEq("R11", "irq low after read", {31'h0, irq}, 32'h0);
    busWrite(4'd5, 32'h8000_0000);
    busWrite(4'd5, 32'h0000_0000);
    checkEq("R10", "write 0 clears test bit", {31'h0, irq}, 32'h0);
    busRead(4'd5, v); checkEq("R10", "register clear", v, 32'h0);
  endtask

  task automatic testInfo();
    logic [31:0] v;
    busRead(4'd6, v); checkEq("R12", "info word", v, 32'h1);
    busWrite(4'd6, 32'h1234_5678);
    busRead(4'd6, v); checkEq("R12", "info after write", v, 32'h1);
    busRead(4'd12, v); checkEq("R12", "unmapped word", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testIdent();
    testRxFrame(8'h11, 5);
    testRxFrame(8'h5A, 1);
    testTx(8'h23, 4);
    testTx(8'h70, 1);
    testTestBit();
    testInfo();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule